// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the modem-status portion of a serial port. It watches four active-low handshake lines from the attached peer: carrier present, ring, peer ready and clear-to-send. It reports their asserted state as an 8-bit status word. The upper nibble of the word carries the current levels. The lower nibble carries sticky change flags, which a CPU read of the word clears. An interrupt request stays high while any change flag is set.

For self-test, a loopback switch replaces the four external lines with four bits from the modem control register. Change detection then runs on those bits, so software can toggle a control output and see the matching flag set. The block also gates the transmitter. With hardware flow control on and clear-to-send deasserted, the gate withholds permission for the next character, but it never withdraws permission while a character is being shifted out.

The external lines are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops. Detection of changes is held off until the synchronizer and the history register hold real samples, so leaving reset never produces a spurious flag.

Top module: `mstat_reg`

## Requirements
- R1: With loopback off, `rd_data[7]`, `[6]`, `[5]` and `[4]` are the inverses of `carrier_n`, `ring_n`, `peer_ready_n` and `peer_clear_n`. A pin change appears in the status bit after `SYNC_STAGES` rising clock edges (default 2).
- R2: Flag bits `rd_data[3]`, `[1]` and `[0]` belong to status bits 7, 5 and 4. Each flag is set on the clock edge after its status bit changes in either direction.
- R3: Flag bit `rd_data[2]` is set only when status bit 6 goes from 1 to 0, which is the ring pin going from low to high. A 0-to-1 change of status bit 6 leaves it clear.
- R4: A flag that is set stays set until a clock edge at which `rd_strobe` is high. That edge clears every flag.
- R5: If a change is detected in the same cycle as a read, its flag is set after that edge and is not cleared.
- R6: `irq` is high exactly when any of `rd_data[3:0]` is 1.
- R7: With `loop_en` high, `rd_data[7:4]` equals `{ctl_aux2, ctl_aux1, ctl_term_rdy, ctl_req_send}`, and the four external pins have no effect on `rd_data`.
- R8: In loopback, changes of the four control bits set the flags by the rules of R2 and R3, one clock edge after the change.
- R9: `tx_permit` is updated only at clock edges where `tx_busy` is low. It then takes the value 1 when `flow_en` is low, and otherwise the value of status bit 4. While `tx_busy` is high it holds its value.
- R10: Reset clears all flags, `irq` and `tx_permit`. A pin already asserted while reset is applied shows in the status bits after release without setting its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_n | input | 1 | Carrier-present line from peer, active low |
| ring_n | input | 1 | Ring line from peer, active low |
| peer_ready_n | input | 1 | Peer-ready line, active low |
| peer_clear_n | input | 1 | Clear-to-send line, active low |
| loop_en | input | 1 | Loopback select |
| ctl_aux2 | input | 1 | Control bit looped to status bit 7 |
| ctl_aux1 | input | 1 | Control bit looped to status bit 6 |
| ctl_term_rdy | input | 1 | Terminal-ready control bit looped to status bit 5 |
| ctl_req_send | input | 1 | Request-to-send control bit looped to status bit 4 |
| flow_en | input | 1 | Hardware flow control enable |
| tx_busy | input | 1 | A character is being shifted out |
| rd_strobe | input | 1 | CPU read of the status word |
| rd_data | output | 8 | Status word: levels [7:4], change flags [3:0] |
| irq | output | 1 | Modem-status interrupt request |
| tx_permit | output | 1 | Transmitter may start the next character |

## Verification
The hardest cases to reach are the ones where two things happen on the same edge. One is a change that arrives in the very cycle the CPU reads. The other is a level change of clear-to-send while a character is in flight. Through the pins, the timing of either depends on the synchronizer latency. The bench therefore drives loopback control bits, whose effect reaches the detector with no delay, so a read can be placed exactly on the detection cycle. The gate is tested by raising `tx_busy` before dropping clear-to-send and holding it across the synchronizer delay. A pin held asserted through reset exercises the arming logic.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   localparam int LINES    = 4;
   localparam int CLR_IDX  = 0;
   localparam int RDY_IDX  = 1;
   localparam int RING_IDX = 2;
   localparam int CARR_IDX = 3;
   typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mstat_delta.sv
module mstat_delta #(
   parameter int               LINES      = 4,
   parameter logic [LINES-1:0] FALL_ONLY  = '0,
   parameter int               ARM_CYCLES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] level,
   input  logic             rd_clr,
   output logic [LINES-1:0] flags,
   output logic [LINES-1:0] hit
);
   localparam int CW = $clog2(ARM_CYCLES + 1);

   logic [CW-1:0]    arm_cnt;
   logic             armed;
   logic [LINES-1:0] prev;

   assign armed = (arm_cnt == CW'(ARM_CYCLES));

   // hold off detection until synchronizer and history hold real samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arm_cnt <= '0;
      else if (!armed) arm_cnt <= arm_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= level;
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      if (FALL_ONLY[i]) begin : g_fall
         assign hit[i] = armed & prev[i] & ~level[i];
      end else begin : g_any
         assign hit[i] = armed & (prev[i] ^ level[i]);
      end
   end

   // a fresh event wins over the clear of the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (rd_clr ? '0 : flags) | hit;
   end
endmodule

// File: rtl/mstat_txgate.sv
module mstat_txgate (
   input  logic clk,
   input  logic rst_n,
   input  logic flow_en,
   input  logic clear_lvl,
   input  logic busy,
   output logic permit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     permit <= 1'b0;
      else if (!busy) permit <= ~flow_en | clear_lvl;
   end
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
   import mstat_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       carrier_n,
   input  logic       ring_n,
   input  logic       peer_ready_n,
   input  logic       peer_clear_n,
   input  logic       loop_en,
   input  logic       ctl_aux2,
   input  logic       ctl_aux1,
   input  logic       ctl_term_rdy,
   input  logic       ctl_req_send,
   input  logic       flow_en,
   input  logic       tx_busy,
   input  logic       rd_strobe,
   output logic [7:0] rd_data,
   output logic       irq,
   output logic       tx_permit
);
   localparam int        ARM_CYCLES = SYNC_STAGES + 1;
   localparam line_vec_t FALL_MASK  = line_vec_t'(1) << RING_IDX;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mstat_reg: SYNC_STAGES must be at least 2");
   end
   if (2 * LINES != 8) begin : g_bad_lines
      $error("mstat_reg: status word needs exactly four lines");
   end

   line_vec_t pin_raw, pin_sync, pin_lvl, loop_lvl, eff_lvl, flags, delta_hit;

   assign pin_raw[CLR_IDX]  = peer_clear_n;
   assign pin_raw[RDY_IDX]  = peer_ready_n;
   assign pin_raw[RING_IDX] = ring_n;
   assign pin_raw[CARR_IDX] = carrier_n;

   assign loop_lvl[CLR_IDX]  = ctl_req_send;
   assign loop_lvl[RDY_IDX]  = ctl_term_rdy;
   assign loop_lvl[RING_IDX] = ctl_aux1;
   assign loop_lvl[CARR_IDX] = ctl_aux2;

   mstat_sync #(
      .WIDTH   (LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_sync)
   );

   assign pin_lvl = ~pin_sync;
   assign eff_lvl = loop_en ? loop_lvl : pin_lvl;

   mstat_delta #(
      .LINES      (LINES),
      .FALL_ONLY  (FALL_MASK),
      .ARM_CYCLES (ARM_CYCLES)
   ) u_delta (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (eff_lvl),
      .rd_clr (rd_strobe),
      .flags  (flags),
      .hit    (delta_hit)
   );

   mstat_txgate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .flow_en   (flow_en),
      .clear_lvl (eff_lvl[CLR_IDX]),
      .busy      (tx_busy),
      .permit    (tx_permit)
   );

   assign rd_data = {eff_lvl, flags};
   assign irq     = |flags;
endmodule

// File: rtl/mstat_chk.sv
module mstat_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_strobe,
   input logic       loop_en,
   input logic       ctl_aux2,
   input logic       ctl_aux1,
   input logic       ctl_term_rdy,
   input logic       ctl_req_send,
   input logic       tx_busy,
   input logic       tx_permit,
   input logic [7:0] rd_data,
   input logic       irq,
   input logic [3:0] delta_hit
);
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> rd_data[3:0] == $past(delta_hit)); // R4
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> (rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])); // R4
   AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (rd_data[3:0] != 4'd0)); // R6
   AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> rd_data[7:4] == {ctl_aux2, ctl_aux1, ctl_term_rdy, ctl_req_send}); // R7
   AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> $stable(tx_permit)); // R9
   AST_RING_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[2]) |-> !$past(rd_data[6])); // R3
endmodule

bind mstat_reg mstat_chk u_chk (.*);

// File: tb/mstat_reg_test.sv
module mstat_reg_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic carrier_n = 1'b1, ring_n = 1'b1, peer_ready_n = 1'b1, peer_clear_n = 1'b1;
   logic loop_en = 1'b0, ctl_aux2 = 1'b0, ctl_aux1 = 1'b0, ctl_term_rdy = 1'b0, ctl_req_send = 1'b0;
   logic flow_en = 1'b0, tx_busy = 1'b0, rd_strobe = 1'b0;
   logic [7:0] rd_data;
   logic irq, tx_permit;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   mstat_reg uut (.*);

   // loopback vectors: {ctl aux2,aux1,term_rdy,req_send ; rd_strobe ; expected rd_data}
   localparam int NVEC = 10;
   localparam logic [12:0] VEC [NVEC] = '{
      {4'b0001, 1'b0, 8'h11},   // R8 bit4 rises -> flag0
      {4'b0001, 1'b1, 8'h10},   // R4 read clears
      {4'b0100, 1'b0, 8'h41},   // R3 bit6 rises: no flag2; R2 bit4 falls -> flag0
      {4'b0000, 1'b0, 8'h05},   // R3 bit6 falls -> flag2, flag0 sticky
      {4'b1010, 1'b1, 8'hAA},   // R5 changes in read cycle survive
      {4'b1000, 1'b1, 8'h82},   // R5 bit5 falls during read
      {4'b1000, 1'b1, 8'h80},   // R4 plain read
      {4'b1100, 1'b0, 8'hC0},   // R3 rising ring level sets nothing
      {4'b1110, 1'b1, 8'hE2},   // R5 / R8
      {4'b1110, 1'b1, 8'hE0}    // R4
   };

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_read();
      rd_strobe = 1'b1;
      tick(1);
      rd_strobe = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: run did not finish");
         summary();
         $finish;
      end
   end

   initial begin
      // R10: reset state, with peer-ready held asserted through reset
      peer_ready_n = 1'b0;
      tick(3);
      chk("R10 reset flags/irq", {3'b0, irq, rd_data[3:0]}, 8'h00);
      chk("R10 reset permit", {7'b0, tx_permit}, 8'h00);
      rst_n = 1'b1;
      tick(5);
      chk("R10 no spurious flag after reset", rd_data, 8'h20);
      chk("R10 irq low after reset", {7'b0, irq}, 8'h00);

      // R2: peer-ready deasserts -> status falls, flag1 set
      peer_ready_n = 1'b1;
      tick(3);
      chk("R2 ready change flagged", rd_data, 8'h02);
      chk("R6 irq with flag", {7'b0, irq}, 8'h01);
      tick(4);
      chk("R4 flag sticky without read", rd_data, 8'h02);
      do_read();
      chk("R4 read clears", rd_data, 8'h00);
      chk("R6 irq clears", {7'b0, irq}, 8'h00);

      // R1 latency and R2 flag timing on carrier
      carrier_n = 1'b0;
      tick(2);
      chk("R1 carrier level after sync", rd_data, 8'h80);
      tick(1);
      chk("R2 carrier flag one edge later", rd_data, 8'h88);
      do_read();
      carrier_n = 1'b1;
      tick(4);
      chk("R2 carrier release flagged", rd_data, 8'h08);
      do_read();

      // R3: ring pin low->high only
      ring_n = 1'b0;
      tick(4);
      chk("R3 ring assert no flag", rd_data, 8'h40);
      ring_n = 1'b1;
      tick(2);
      chk("R1 ring level cleared", rd_data, 8'h00);
      tick(1);
      chk("R3 ring trailing flag", rd_data, 8'h04);
      do_read();

      // R1: clear-to-send level
      peer_clear_n = 1'b0;
      tick(3);
      chk("R1 clear level", rd_data[7:4], 8'h01);
      peer_clear_n = 1'b1;
      tick(4);
      do_read();
      chk("R4 cleared before loopback", rd_data, 8'h00);

      // R7: loopback ignores pins
      loop_en = 1'b1;
      tick(2);
      carrier_n = 1'b0; ring_n = 1'b0; peer_ready_n = 1'b0; peer_clear_n = 1'b0;
      tick(5);
      chk("R7 pins ignored in loopback", rd_data, 8'h00);
      carrier_n = 1'b1; ring_n = 1'b1; peer_ready_n = 1'b1; peer_clear_n = 1'b1;
      tick(5);
      chk("R7 pins ignored on release", rd_data, 8'h00);

      // table walk (R3 R4 R5 R7 R8)
      for (int i = 0; i < NVEC; i++) begin
         {ctl_aux2, ctl_aux1, ctl_term_rdy, ctl_req_send} = VEC[i][12:9];
         rd_strobe = VEC[i][8];
         tick(1);
         rd_strobe = 1'b0;
         chk($sformatf("R8 vector %0d rd_data", i), rd_data, VEC[i][7:0]);
         chk($sformatf("R6 vector %0d irq", i), {7'b0, irq}, {7'b0, |VEC[i][3:0]});
      end

      // back to pins, clear
      {ctl_aux2, ctl_aux1, ctl_term_rdy, ctl_req_send} = 4'b0000;
      loop_en = 1'b0;
      tick(2);
      do_read();
      tick(1);

      // R9: transmit gate
      flow_en = 1'b1;
      tick(3);
      chk("R9 gate closed while clear deasserted", {7'b0, tx_permit}, 8'h00);
      peer_clear_n = 1'b0;
      tick(3);
      chk("R9 gate opens on clear", {7'b0, tx_permit}, 8'h01);
      tx_busy = 1'b1;
      tick(1);
      peer_clear_n = 1'b1;
      tick(5);
      chk("R9 gate held during character", {7'b0, tx_permit}, 8'h01);
      tx_busy = 1'b0;
      tick(1);
      chk("R9 gate closes at boundary", {7'b0, tx_permit}, 8'h00);
      flow_en = 1'b0;
      tick(1);
      chk("R9 gate open without flow control", {7'b0, tx_permit}, 8'h01);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule